// File: doc/BRIEF.md
# Shared Bus Arbiter with Fixed and Least-Recently-Used Priority

This block shares one single-clock bus among several masters. Every master has a request input and gets back its own grant output. The arbiter looks at all pending requests and picks one owner using a policy that is set by a parameter. There are two policies. In fixed mode, a lower master index always wins over a higher one. In least-recently-used mode, the master that was just granted drops to the back of a rank list, and the other masters keep their relative order. Grants are registered. An owner keeps the bus for as long as it holds its request. It releases the bus by dropping the request, and only then can another master get a grant.

The block also forms the shared 32-bit address and data bus. Each master's address and data are gated by its own grant, and all the gated values are OR-ed together. A master that does not hold a grant therefore adds all zeros. When nobody owns the bus, the bus reads zero. Masters raise a request and wait for their grant, then drive address and data for as long as they keep the request high.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is high, every grant output is low in the cycle that follows.
- R2: No more than one grant output is high in any cycle.
- R3: A grant output goes high only for a master whose request was high at the clock edge that registered the grant.
- R4: While the owning master keeps its request high, its grant stays high and no other grant is issued.
- R5: When the owner drops its request, its grant falls at the next edge. At that same edge, the bus passes straight to a waiting requester if there is one.
- R6: With no request pending, all grants are low one cycle later.
- R7: If any request is pending at an edge, some grant is high after that edge. The bus never stays idle while requests wait.
- R8: In fixed mode (POLICY = POL_FIXED), a new grant goes to the requesting master with the lowest index.
- R9: In least-recently-used mode (POLICY = POL_LRU), the rank list after reset runs from index 0 (first) to index N_MST-1 (last). A new grant goes to the requester that ranks first. The granted master then moves to the last rank, and the others keep their order.
- R10: While master k is granted, bus_addr equals bits [32k+31:32k] of m_addr and bus_data equals bits [32k+31:32k] of m_data.
- R11: While no grant is high, bus_addr and bus_data are all zeros, whatever the masters drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_MST | Request line per master, bit k for master k |
| m_addr | input | N_MST*32 | Address driven by each master, master k in bits [32k+31:32k] |
| m_data | input | N_MST*32 | Data driven by each master, master k in bits [32k+31:32k] |
| grant | output | N_MST | Registered grant line per master |
| bus_addr | output | 32 | Combined shared address bus |
| bus_data | output | 32 | Combined shared data bus |

## Verification
The bench builds two copies of the block with N_MST = 4 and feeds both the same stimulus. One copy uses POL_FIXED and the other uses POL_LRU. Four masters are few enough that random request patterns often produce contention, handoffs at release and fully idle cycles. A directed sequence also places the fixed and least-recently-used choices on different masters. Because both policies see identical requests, any difference between their grants comes from the rank list alone.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        POL_FIXED = 1'b0,
        POL_LRU   = 1'b1
    } arb_policy_e;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_beat_t;

    localparam int BEAT_W = $bits(bus_beat_t);

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
    parameter int N_MST = 8,
    parameter int IW    = 3
) (
    input  logic [N_MST-1:0] req,
    output logic             win_vld,
    output logic [IW-1:0]    win_idx
);
    // Scan from the top so that the lowest index is written last and wins.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_vld = 1'b1;
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_lru_pick.sv
module arb_lru_pick #(
    parameter int N_MST = 8,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MST-1:0] req,
    input  logic             take,
    output logic             win_vld,
    output logic [IW-1:0]    win_idx
);
    // rank_q[0] holds the master that is served first.
    logic [IW-1:0] rank_q [N_MST];
    logic [IW-1:0] rank_n [N_MST];
    logic [IW-1:0] win_pos;

    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_pos = '0;
        for (int p = N_MST - 1; p >= 0; p--) begin
            if (req[rank_q[p]]) begin
                win_vld = 1'b1;
                win_idx = rank_q[p];
                win_pos = IW'(p);
            end
        end
    end

    // On a grant, every entry below the winner moves up one slot
    // and the winner is placed in the last slot.
    for (genvar p = 0; p < N_MST; p++) begin : g_rank
        if (p < N_MST - 1) begin : g_mid
            assign rank_n[p] = (take && (IW'(p) >= win_pos)) ? rank_q[p+1] : rank_q[p];
        end else begin : g_last
            assign rank_n[p] = take ? win_idx : rank_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < N_MST; p++) rank_q[p] <= IW'(p);
        end else begin
            for (int p = 0; p < N_MST; p++) rank_q[p] <= rank_n[p];
        end
    end
endmodule

// File: rtl/bus_andor_combine.sv
module bus_andor_combine
    import arb_pkg::*;
#(
    parameter int N_MST = 8
) (
    input  bus_beat_t        beats [N_MST],
    input  logic [N_MST-1:0] sel,
    output bus_beat_t        merged
);
    // Each master is masked by its own select line; unselected ones add zero.
    always_comb begin
        merged = '0;
        for (int i = 0; i < N_MST; i++) begin
            merged = merged | (beats[i] & {BEAT_W{sel[i]}});
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int          N_MST  = 8,
    parameter arb_policy_e POLICY = POL_FIXED
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_MST-1:0]          req,
    input  logic [N_MST*ADDR_W-1:0]   m_addr,
    input  logic [N_MST*DATA_W-1:0]   m_data,
    output logic [N_MST-1:0]          grant,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_data
);
    localparam int IW = idx_width(N_MST);

    logic [N_MST-1:0] grant_q;
    logic             owner_keep;
    logic             issue;
    logic             win_vld;
    logic [IW-1:0]    win_idx;

    // The current owner keeps the bus for as long as its request is high.
    assign owner_keep = |(grant_q & req);
    assign issue      = !owner_keep && win_vld;

    if (POLICY == POL_FIXED) begin : g_fixed
        arb_fixed_pick #(.N_MST(N_MST), .IW(IW)) u_pick (
            .req     (req),
            .win_vld (win_vld),
            .win_idx (win_idx)
        );
    end else begin : g_lru
        arb_lru_pick #(.N_MST(N_MST), .IW(IW)) u_pick (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .take    (issue),
            .win_vld (win_vld),
            .win_idx (win_idx)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (!owner_keep) begin
            grant_q <= '0;
            if (win_vld) grant_q[win_idx] <= 1'b1;
        end
    end

    assign grant = grant_q;

    bus_beat_t beats [N_MST];
    bus_beat_t merged;

    for (genvar i = 0; i < N_MST; i++) begin : g_beat
        assign beats[i].addr = m_addr[i*ADDR_W +: ADDR_W];
        assign beats[i].data = m_data[i*DATA_W +: DATA_W];
    end

    bus_andor_combine #(.N_MST(N_MST)) u_combine (
        .beats  (beats),
        .sel    (grant_q),
        .merged (merged)
    );

    assign bus_addr = merged.addr;
    assign bus_data = merged.data;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int N_MST = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [N_MST-1:0] req,
    input logic [N_MST-1:0] grant,
    input logic [31:0]      bus_addr,
    input logic [31:0]      bus_data
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (grant == '0));

    p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~$past(req)) == '0));

    p_owner_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (|(grant & req)) |=> (grant == $past(grant)));

    p_release_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (|(grant & ~req)) |=> ((grant & $past(grant)) == '0));

    p_idle_no_grant_r6: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (grant == '0));

    p_no_waste_r7: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> (grant != '0));

    p_zero_bus_r11: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |-> ((bus_addr == '0) && (bus_data == '0)));
endmodule

bind bus_arbiter bus_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .grant    (grant),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    import arb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NM-1:0]   req = '0;
    logic [NM*32-1:0] m_addr = '0;
    logic [NM*32-1:0] m_data = '0;
    logic [NM-1:0]   gnt_l, gnt_f;
    logic [31:0]     ba_l, bd_l, ba_f, bd_f;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arbiter #(.N_MST(NM), .POLICY(POL_LRU)) u_dut (
        .clk(clk), .rst(rst), .req(req), .m_addr(m_addr), .m_data(m_data),
        .grant(gnt_l), .bus_addr(ba_l), .bus_data(bd_l));

    bus_arbiter #(.N_MST(NM), .POLICY(POL_FIXED)) u_dut_fx (
        .clk(clk), .rst(rst), .req(req), .m_addr(m_addr), .m_data(m_data),
        .grant(gnt_f), .bus_addr(ba_f), .bus_data(bd_f));

    // Behavioural reference: owner per policy, rank queue for LRU.
    int own_l = -1, own_f = -1;
    int rankq[$];
    logic [NM-1:0] pr = '0;
    string tag_l = "R1", tag_f = "R1";

    function automatic int pick_fixed(input logic [NM-1:0] r);
        for (int i = 0; i < NM; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic int pick_lru(input logic [NM-1:0] r);
        foreach (rankq[k]) if (r[rankq[k]]) return rankq[k];
        return -1;
    endfunction

    always @(posedge clk) begin
        pr = req;
        if (rst) begin
            own_l = -1; own_f = -1;
            rankq = {};
            for (int i = 0; i < NM; i++) rankq.push_back(i);
            tag_l = "R1"; tag_f = "R1";
        end else begin
            if (own_f >= 0 && req[own_f]) tag_f = "R4";
            else begin
                int w;
                w = pick_fixed(req);
                if (w < 0) tag_f = "R6";
                else if (own_f >= 0) tag_f = "R5,R8";
                else tag_f = "R8";
                own_f = w;
            end
            if (own_l >= 0 && req[own_l]) tag_l = "R4";
            else begin
                int w;
                w = pick_lru(req);
                if (w < 0) tag_l = "R6";
                else begin
                    tag_l = (own_l >= 0) ? "R5,R9" : "R9";
                    foreach (rankq[k]) if (rankq[k] == w) begin rankq.delete(k); break; end
                    rankq.push_back(w);
                end
                own_l = w;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_one(input string pol, input string tag, input int own,
                             input logic [NM-1:0] g, input logic [31:0] ba, input logic [31:0] bd);
        logic [NM-1:0] eg;
        logic [31:0] ea, ed;
        eg = (own < 0) ? '0 : (NM'(1) << own);
        ea = (own < 0) ? 32'h0 : m_addr[own*32 +: 32];
        ed = (own < 0) ? 32'h0 : m_data[own*32 +: 32];
        chk({pol, " grant ", tag}, 32'(g), 32'(eg));
        chk({pol, " R2 onehot"}, 32'($countones(g) <= 1), 32'd1);
        chk({pol, " R3 grant within req"}, 32'(g & ~pr), 32'h0);
        if (!rst && pr != '0) chk({pol, " R7 no idle"}, 32'(g != '0), 32'd1);
        chk({pol, (own < 0) ? " R11 addr" : " R10 addr"}, ba, ea);
        chk({pol, (own < 0) ? " R11 data" : " R10 data"}, bd, ed);
    endtask

    int cyc = 0;

    task automatic step(input logic [NM-1:0] r);
        @(negedge clk);
        check_one("lru", tag_l, own_l, gnt_l, ba_l, bd_l);
        check_one("fixed", tag_f, own_f, gnt_f, ba_f, bd_f);
        cyc++;
        req = r;
        for (int i = 0; i < NM; i++) begin
            m_addr[i*32 +: 32] = 32'hA000_0000 | (32'(i) << 16) | 32'(cyc);
            m_data[i*32 +: 32] = ~(32'h5500_0000 | (32'(i) << 20) | 32'(cyc * 3));
        end
    endtask

    task automatic run(input logic [NM-1:0] r, input int n);
        for (int k = 0; k < n; k++) step(r);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        // R1: requests high during reset must not produce grants.
        run(4'b1111, 3);
        rst = 1'b0;
        run(4'b0000, 2);          // R6 idle, R11 zero bus
        run(4'b0100, 3);          // single requester
        run(4'b1111, 3);          // R4 owner 2 holds
        run(4'b1011, 2);          // release: both pick 0
        run(4'b1010, 2);          // fixed 1, LRU 1
        run(4'b1001, 2);          // fixed 0, LRU 3 (R8 vs R9)
        run(4'b1101, 2);
        run(4'b0000, 2);
        for (int k = 0; k < 800; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0] | lf[7:4]);
        end
        run(4'b0000, 3);
        rst = 1'b1;
        run(4'b1111, 2);          // R1 again mid-run
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule